// File: doc/BRIEF.md
# Burst-of-Two Double-Rate SRAM with Late Writes

This block models a synchronous static memory whose data path moves two words for every command. Reads and writes both use one address bus. On the device this data path would be a single bidirectional bus carrying one word per clock phase. Here it is kept in one clock domain: each direction has a rise-phase word port and a fall-phase word port, and one output enable stands for the state of the bus drivers. Commands are sampled on the rising clock edge. A select strobe marks a command, and a read/write level chooses between a read (high) and a write (low).

Reads are pipelined. The two words appear together one clock edge after the command is registered. Writes are late: the two words and their byte enables arrive one cycle after the write command. They then wait in a write buffer until the next write's data arrives. A read that hits the buffered write returns the buffered bytes merged over the array contents. The block also drives a complementary echo clock pair. The pair runs freely from the first clock edge after reset and follows the phase of the output data.

Top module: `ddr2b_sram`

## Requirements
- R1: While rst_n is low, dq_oe, dq_rise, dq_fall, echo_p and echo_n are all 0.
- R2: A read command (cmd_sel=1, cmd_rd=1) registered at clock edge k gives dq_oe=1 and the read words on dq_rise/dq_fall after edge k+1.
- R3: A burst starting at word address A returns word A on dq_rise and word A XOR 1 on dq_fall. The burst wraps inside the aligned pair, so odd start addresses return the lower word second.
- R4: Read commands on consecutive edges keep dq_oe high without a gap, and a new word pair is shown on each cycle.
- R5: After the last read burst completes, dq_oe returns to 0 on the following edge without any command, and dq_rise and dq_fall read 0 whenever dq_oe is 0.
- R6: A write command registered at edge k stores the wd_rise/wd_fall values sampled at edge k+1, at A and A XOR 1. Write-data values present at any other edge are ignored.
- R7: Bit j of wbe_rise (wbe_fall) enables bits [8j+7:8j] of the rise (fall) word. Bytes whose enable is 0 keep their previous contents.
- R8: A read of a word whose late write is still buffered returns the buffered bytes for the enabled byte lanes and the older stored bytes for the others. This includes a read issued on the edge that delivers the write data.
- R9: From the first rising edge after reset release, echo_p is high during the high clock phase and low during the low phase, and echo_n is its complement.
- R10: A write command produces no read output: dq_oe stays 0 for its slot.
- R11: With cmd_sel=0 nothing is read or written, whatever cmd_rd, cmd_addr and the write-data inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; commands sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cmd_sel | input | 1 | Command strobe; 1 starts a read or write burst |
| cmd_rd | input | 1 | 1 = read, 0 = write, when cmd_sel is 1 |
| cmd_addr | input | 4 | Word address of the burst's first word |
| wd_rise | input | 16 | Late-write word for the start address |
| wd_fall | input | 16 | Late-write word for the partner address (XOR 1) |
| wbe_rise | input | 2 | Byte enables for wd_rise, sampled with the data |
| wbe_fall | input | 2 | Byte enables for wd_fall, sampled with the data |
| dq_rise | output | 16 | Read word for the start address |
| dq_fall | output | 16 | Read word for the partner address |
| dq_oe | output | 1 | Output-driver enable; 0 stands for high impedance |
| echo_p | output | 1 | Free-running echo clock |
| echo_n | output | 1 | Complement of echo_p |

## Verification
The latency properties assume that cmd_sel and cmd_rd are held at known levels from time zero and are changed only away from the rising edge. The bench drives every input on the falling edge and keeps cmd_sel low through reset. The echo property assumes rst_n is released between rising edges, and the bench releases it on a falling edge. The data checks assume that every word has been written before it is first read, so the bench fills the whole array before any read sweep. Write-data inputs carry scrambled values on every cycle that is not a late-write data cycle, so a design that samples data in the wrong slot shows a mismatch.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/ddr2b_cmd_stage.sv
module ddr2b_cmd_stage
  import ddr2b_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic          rd,
  input  logic [AW-1:0] addr,
  output op_e           op_q,
  output logic [AW-1:0] addr_q
);
  op_e op_d;

  always_comb begin
    op_d = OP_IDLE;
    if (sel) op_d = rd ? OP_READ : OP_WRITE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) op_q <= OP_IDLE;
    else        op_q <= op_d;
  end

  always_ff @(posedge clk) begin
    if (sel) addr_q <= addr;
  end
endmodule

// File: rtl/ddr2b_wbuf.sv
module ddr2b_wbuf #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [AW-1:0]         addr_q,
  input  logic [DW-1:0]         wd_r,
  input  logic [DW-1:0]         wd_f,
  input  logic [NB-1:0]         be_r,
  input  logic [NB-1:0]         be_f,
  output logic                  pend_v,
  output logic [AW-1:0]         pend_addr,
  output logic [1:0][DW-1:0]    pend_d,
  output logic [1:0][NB-1:0]    pend_be,
  output logic                  commit
);
  logic pend_v_d;

  assign commit = load && pend_v;

  always_comb begin
    pend_v_d = pend_v;
    if (load) pend_v_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_v <= 1'b0;
    else        pend_v <= pend_v_d;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      pend_addr <= addr_q;
      pend_d    <= {wd_f, wd_r};
      pend_be   <= {be_f, be_r};
    end
  end
endmodule

// File: rtl/ddr2b_array.sv
module ddr2b_array #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic               clk,
  input  logic               we,
  input  logic [AW-1:0]      wbase,
  input  logic [1:0][DW-1:0] wd,
  input  logic [1:0][NB-1:0] wbe,
  input  logic [AW-1:0]      rbase,
  output logic [1:0][DW-1:0] rd
);
  localparam int DEPTH = 1 << AW;
  localparam int BW    = DW / NB;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      for (int w = 0; w < 2; w++) begin
        for (int b = 0; b < NB; b++) begin
          if (wbe[w][b]) mem[wbase ^ AW'(w)][b*BW +: BW] <= wd[w][b*BW +: BW];
        end
      end
    end
  end

  for (genvar w = 0; w < 2; w++) begin : g_rport
    assign rd[w] = mem[rbase ^ AW'(w)];
  end
endmodule

// File: rtl/ddr2b_rdout.sv
module ddr2b_rdout #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               go,
  input  logic [AW-1:0]      raddr,
  input  logic [1:0][DW-1:0] arr_rd,
  input  logic               pend_v,
  input  logic [AW-1:0]      pend_addr,
  input  logic [1:0][DW-1:0] pend_d,
  input  logic [1:0][NB-1:0] pend_be,
  output logic [DW-1:0]      dq_r,
  output logic [DW-1:0]      dq_f,
  output logic               oe
);
  localparam int BW = DW / NB;

  logic               hit;
  logic [1:0]         pidx;
  logic [1:0][DW-1:0] merged;
  logic [DW-1:0]      dq_r_d, dq_f_d;
  logic               oe_d;

  assign hit = pend_v && (raddr[AW-1:1] == pend_addr[AW-1:1]);

  for (genvar w = 0; w < 2; w++) begin : g_word
    assign pidx[w] = raddr[0] ^ pend_addr[0] ^ (w == 1);
    for (genvar b = 0; b < NB; b++) begin : g_byte
      assign merged[w][b*BW +: BW] = (hit && pend_be[pidx[w]][b])
                                   ? pend_d[pidx[w]][b*BW +: BW]
                                   : arr_rd[w][b*BW +: BW];
    end
  end

  always_comb begin
    oe_d   = go;
    dq_r_d = '0;
    dq_f_d = '0;
    if (go) begin
      dq_r_d = merged[0];
      dq_f_d = merged[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe   <= 1'b0;
      dq_r <= '0;
      dq_f <= '0;
    end else begin
      oe   <= oe_d;
      dq_r <= dq_r_d;
      dq_f <= dq_f_d;
    end
  end
endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
  import ddr2b_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_sel,
  input  logic          cmd_rd,
  input  logic [AW-1:0] cmd_addr,
  input  logic [DW-1:0] wd_rise,
  input  logic [DW-1:0] wd_fall,
  input  logic [NB-1:0] wbe_rise,
  input  logic [NB-1:0] wbe_fall,
  output logic [DW-1:0] dq_rise,
  output logic [DW-1:0] dq_fall,
  output logic          dq_oe,
  output logic          echo_p,
  output logic          echo_n
);
  op_e                op_q;
  logic [AW-1:0]      addr_q;
  logic               pend_v, commit;
  logic [AW-1:0]      pend_addr;
  logic [1:0][DW-1:0] pend_d, arr_rd;
  logic [1:0][NB-1:0] pend_be;
  logic               echo_run, echo_run_d;

  ddr2b_cmd_stage #(.AW(AW)) u_cmd (
    .clk(clk), .rst_n(rst_n), .sel(cmd_sel), .rd(cmd_rd), .addr(cmd_addr),
    .op_q(op_q), .addr_q(addr_q)
  );

  ddr2b_wbuf #(.AW(AW), .DW(DW), .NB(NB)) u_wbuf (
    .clk(clk), .rst_n(rst_n), .load(op_q == OP_WRITE), .addr_q(addr_q),
    .wd_r(wd_rise), .wd_f(wd_fall), .be_r(wbe_rise), .be_f(wbe_fall),
    .pend_v(pend_v), .pend_addr(pend_addr), .pend_d(pend_d),
    .pend_be(pend_be), .commit(commit)
  );

  ddr2b_array #(.AW(AW), .DW(DW), .NB(NB)) u_array (
    .clk(clk), .we(commit), .wbase(pend_addr), .wd(pend_d), .wbe(pend_be),
    .rbase(addr_q), .rd(arr_rd)
  );

  ddr2b_rdout #(.AW(AW), .DW(DW), .NB(NB)) u_rdout (
    .clk(clk), .rst_n(rst_n), .go(op_q == OP_READ), .raddr(addr_q),
    .arr_rd(arr_rd), .pend_v(pend_v), .pend_addr(pend_addr),
    .pend_d(pend_d), .pend_be(pend_be),
    .dq_r(dq_rise), .dq_f(dq_fall), .oe(dq_oe)
  );

  assign echo_run_d = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) echo_run <= 1'b0;
    else        echo_run <= echo_run_d;
  end

  assign echo_p = clk & echo_run;
  assign echo_n = ~clk & echo_run;
endmodule

// File: rtl/ddr2b_sram_chk.sv
module ddr2b_sram_chk #(
  parameter int AW = 4,
  parameter int DW = 16,
  parameter int NB = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_sel,
  input logic          cmd_rd,
  input logic [DW-1:0] dq_rise,
  input logic [DW-1:0] dq_fall,
  input logic          dq_oe,
  input logic          echo_p,
  input logic          echo_n
);
  p_rd_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_sel && cmd_rd) |-> ##2 dq_oe);

  // R5 and R10: no read registered means no driven slot
  p_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_sel && cmd_rd) |-> ##2 !dq_oe);

  p_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_oe |-> (dq_rise == '0 && dq_fall == '0));

  p_echo_r9: assert property (@(negedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (echo_p && !echo_n));
endmodule

bind ddr2b_sram ddr2b_sram_chk #(.AW(AW), .DW(DW), .NB(NB)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_sel(cmd_sel), .cmd_rd(cmd_rd),
  .dq_rise(dq_rise), .dq_fall(dq_fall), .dq_oe(dq_oe),
  .echo_p(echo_p), .echo_n(echo_n)
);

// File: tb/tb_ddr2b_sram.sv
module tb_ddr2b_sram;
  localparam int AW = 4;
  localparam int DW = 16;
  localparam int NB = 2;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cmd_sel, cmd_rd;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] wd_rise, wd_fall;
  logic [NB-1:0] wbe_rise, wbe_fall;
  logic [DW-1:0] dq_rise, dq_fall;
  logic          dq_oe, echo_p, echo_n;

  ddr2b_sram #(.AW(AW), .DW(DW), .NB(NB)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_sel(cmd_sel), .cmd_rd(cmd_rd),
    .cmd_addr(cmd_addr), .wd_rise(wd_rise), .wd_fall(wd_fall),
    .wbe_rise(wbe_rise), .wbe_fall(wbe_fall), .dq_rise(dq_rise),
    .dq_fall(dq_fall), .dq_oe(dq_oe), .echo_p(echo_p), .echo_n(echo_n)
  );

  always #2 clk = ~clk;

  int            ncmp = 0;
  int            nbad = 0;
  bit            done = 0;
  logic [DW-1:0] mdl [DEPTH];
  logic          exp_v = 0;
  logic [DW-1:0] exp_r = '0, exp_f = '0;
  string         exp_tag = "R2";
  logic          pw = 0;
  logic [AW-1:0] pwa = '0;
  int            gcnt = 0;

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    ncmp++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] junk();
    gcnt++;
    return DW'(32'hB5C3 ^ (gcnt * 32'h1F35));
  endfunction

  function automatic logic [DW-1:0] dat(input int a, input int k);
    return DW'((a * 32'h0101) ^ (k * 32'h3C5A) ^ 32'h5A00);
  endfunction

  // one command slot: drive at negedge, check the previous slot's result at the next negedge
  task automatic step(input logic s, input logic r, input logic [AW-1:0] a,
                      input logic [DW-1:0] dr, input logic [DW-1:0] df,
                      input logic [NB-1:0] br, input logic [NB-1:0] bf,
                      input string tag);
    logic nv;
    logic [DW-1:0] nr, nf;
    string t;
    cmd_sel = s; cmd_rd = r; cmd_addr = a;
    wd_rise = dr; wd_fall = df; wbe_rise = br; wbe_fall = bf;
    if (pw) begin
      for (int b = 0; b < NB; b++) begin
        if (br[b]) mdl[pwa][b*8 +: 8] = dr[b*8 +: 8];
        if (bf[b]) mdl[pwa ^ AW'(1)][b*8 +: 8] = df[b*8 +: 8];
      end
    end
    nv = s && r;
    nr = mdl[a];
    nf = mdl[a ^ AW'(1)];
    @(posedge clk);
    @(negedge clk);
    t = exp_v ? exp_tag : (pw ? "R10" : "R5");
    chk(t, {{(DW-1){1'b0}}, dq_oe}, {{(DW-1){1'b0}}, exp_v});
    chk(t, dq_rise, exp_v ? exp_r : '0);
    chk(t, dq_fall, exp_v ? exp_f : '0);
    exp_v = nv; exp_r = nr; exp_f = nf; exp_tag = tag;
    pw = s && !r; pwa = a;
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, '0, junk(), junk(), '1, '1, tag);
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      nbad++;
      ncmp++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_sel = 1'b0; cmd_rd = 1'b0; cmd_addr = '0;
    wd_rise = '0; wd_fall = '0; wbe_rise = '0; wbe_fall = '0;
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    // R1 reset state
    chk("R1", {14'd0, echo_p, echo_n}, '0);
    chk("R1", {15'd0, dq_oe}, '0);
    chk("R1", dq_rise | dq_fall, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R6: fill array with back-to-back late writes; data follows each command
    for (int i = 0; i <= DEPTH/2; i++) begin
      if (i == 0)
        step(1'b1, 1'b0, AW'(0), junk(), junk(), '1, '1, "R6");
      else if (i < DEPTH/2)
        step(1'b1, 1'b0, AW'(2*i), dat(2*i-2, 0), dat(2*i-1, 0), '1, '1, "R6");
      else
        step(1'b0, 1'b0, '0, dat(2*i-2, 0), dat(2*i-1, 0), '1, '1, "R6");
    end
    idle("R5");

    // R2, R3: isolated reads of every start address, idle between
    for (int a = 0; a < DEPTH; a++) begin
      step(1'b1, 1'b1, AW'(a), junk(), junk(), '1, '1, (a % 2) ? "R3" : "R2");
      idle("R5");
    end

    // R4: continuous reads, descending
    for (int a = DEPTH - 1; a >= 0; a--)
      step(1'b1, 1'b1, AW'(a), junk(), junk(), '1, '1, "R4");
    idle("R5");
    idle("R5");

    // R11: deselected cycles with read/write levels and junk data change nothing
    step(1'b0, 1'b1, AW'(3), junk(), junk(), '1, '1, "R11");
    step(1'b0, 1'b0, AW'(6), junk(), junk(), '1, '1, "R11");
    step(1'b0, 1'b0, AW'(6), junk(), junk(), '1, '1, "R11");
    for (int a = 0; a < DEPTH; a += 3)
      step(1'b1, 1'b1, AW'(a), junk(), junk(), '1, '1, "R11");
    idle("R5");

    // R7: byte-enable sweep, every enable pattern on both words
    for (int i = 0; i <= DEPTH/2; i++) begin
      if (i == 0)
        step(1'b1, 1'b0, AW'(0), junk(), junk(), '1, '1, "R7");
      else if (i < DEPTH/2)
        step(1'b1, 1'b0, AW'(2*i), dat(2*i-2, 1), dat(2*i-1, 1),
             NB'((i-1) % 4), NB'(i % 4), "R7");
      else
        step(1'b0, 1'b0, '0, dat(2*i-2, 1), dat(2*i-1, 1),
             NB'((i-1) % 4), NB'(i % 4), "R7");
    end
    for (int a = 0; a < DEPTH; a++)
      step(1'b1, 1'b1, AW'(a), junk(), junk(), '1, '1, "R7");
    idle("R5");

    // R8: reads that hit the buffered late write
    step(1'b1, 1'b0, AW'(5), junk(), junk(), '1, '1, "R10");
    step(1'b1, 1'b1, AW'(5), dat(5, 2), dat(4, 2), 2'b01, 2'b10, "R8");
    step(1'b1, 1'b1, AW'(4), junk(), junk(), '1, '1, "R8");
    step(1'b1, 1'b0, AW'(4), junk(), junk(), '1, '1, "R10");
    step(1'b1, 1'b0, AW'(4), dat(4, 3), dat(5, 3), 2'b11, 2'b11, "R10");
    step(1'b1, 1'b1, AW'(4), dat(4, 4), dat(5, 4), 2'b10, 2'b01, "R8");
    step(1'b1, 1'b1, AW'(5), junk(), junk(), '1, '1, "R8");
    step(1'b1, 1'b1, AW'(9), junk(), junk(), '1, '1, "R8");
    idle("R5");

    // R6: data on the bus with the command is not what gets stored
    step(1'b1, 1'b0, AW'(8), 16'hDEAD, 16'hBEEF, '1, '1, "R6");
    step(1'b0, 1'b0, '0, dat(8, 5), dat(9, 5), '1, '1, "R6");
    step(1'b0, 1'b0, '0, 16'h1111, 16'h2222, '1, '1, "R6");
    step(1'b1, 1'b1, AW'(8), junk(), junk(), '1, '1, "R6");
    step(1'b1, 1'b1, AW'(9), junk(), junk(), '1, '1, "R6");
    idle("R5");
    idle("R5");

    // R9: echo pair follows the clock phases
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1;
      chk("R9", {14'd0, echo_p, echo_n}, 16'd2);
      @(negedge clk); #1;
      chk("R9", {14'd0, echo_p, echo_n}, 16'd1);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
    $finish;
  end
endmodule